// File: doc/BRIEF.md
# Palette lookup with pixel masking

This block is the colour lookup stage of a display pipeline. Every pixel clock it takes an 8-bit pixel index and ANDs it bit by bit with a programmable mask register. The result addresses a 256-entry palette, and the block returns the palette's red, green and blue codes for the output converters. A true-colour bypass sends the 24-bit pixel word straight to the outputs and skips both the mask and the palette. A resolution control selects between 8-bit colour and 6-bit colour.

A host reaches the block through a byte-wide register port with a 2-bit select: 0 is the write address, 1 is palette data, 2 is the read address and 3 is the mask. Palette entries move as three bytes in red, green, blue order. Two byte-phase state machines track that order, one for writes and one for reads. Each has the states `PH_RED`, `PH_GREEN` and `PH_BLUE`. A data access moves a machine through `PH_RED -> PH_GREEN -> PH_BLUE -> PH_RED`, and loading its address register sends it back to `PH_RED`. The pixel path reads the palette through its own port, so host traffic never holds it up. When `host_wr` and `host_rd` are both high, the read is dropped.

Top module: `clut_mask_stage`

## Requirements
- R1: The colour outputs in the second cycle after a pixel is presented equal the palette entry at index `pix_data[7:0] & mask`, with red in entry bits 23:16, green in 15:8 and blue in 7:0.
- R2: With `pix_bypass` high, the outputs two cycles later are `pix_data[23:16]`, `pix_data[15:8]` and `pix_data[7:0]`, unaffected by the mask and the palette.
- R3: A host write with select 3 loads the mask, which has no reset value. A host read with select 3 returns the mask.
- R4: Data writes (select 1) collect red, then green, then blue. The entry at the write address changes only on the blue byte, and the write address then increments, wrapping from 255 to 0.
- R5: A host write with select 0 loads the write address and restarts the write sequence at red. A read with select 0 returns the write address.
- R6: A host write with select 2 loads a separate read address and restarts the read sequence at red. Data reads (select 1) return red, green, then blue of the entry at the read address, and the read address increments after blue. A read with select 2 returns the read address.
- R7: In 6-bit mode (`dac6_mode` high), a data write ignores bits 7:6 and stores the byte as `{wdata[5:0], 2'b00}`.
- R8: In 6-bit mode, a data read returns `{2'b00, stored[7:2]}`, so bits 7:6 read as zero. In 8-bit mode it returns the stored byte.
- R9: In 6-bit mode, bits 1:0 of every colour output are zero, both in lookup and in bypass. The mode is taken with the pixel.
- R10: Host accesses issued in the same cycles as pixels leave the pixel results and their two-cycle timing unchanged.
- R11: After reset, both sequences are at red, both addresses are 0, and `host_rdata` and all colour outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_data | input | 24 | Pixel word; bits 7:0 are the index, all 24 bits are used in bypass |
| pix_bypass | input | 1 | True-colour bypass for this pixel |
| dac6_mode | input | 1 | 6-bit colour resolution when high |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 2 | 0 write address, 1 palette data, 2 read address, 3 mask |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid the cycle after `host_rd` |
| red_out | output | 8 | Red code |
| grn_out | output | 8 | Green code |
| blu_out | output | 8 | Blue code |

## Verification
A write sequence stuck in the wrong phase, or a write address that is wrong, shows up when the next triplet lands in the wrong entry or with its bytes rotated. That becomes visible one cycle after a host read of the entry, or two cycles after a pixel that addresses it. A wrong read phase or read address corrupts the very next data read. A wrong mask or a dropped 6-bit flag alters the colour outputs exactly two cycles after the affected pixel. The bench therefore mixes random pixels, masks and modes with host reads in the same cycles, and it uses directed writes to cover the partial-triplet, restart and 6-bit cases.

// File: rtl/clut_pkg.sv
package clut_pkg;

    // Geometry of the lookup stage
    localparam int CLUT_IDX_W = 8;   // pixel index width
    localparam int CLUT_CH_W  = 8;   // bits per colour channel
    localparam int CLUT_LO_W  = 2;   // low bits dropped in 6-bit mode

    // Host register select codes
    localparam logic [1:0] SEL_WADDR = 2'd0;
    localparam logic [1:0] SEL_DATA  = 2'd1;
    localparam logic [1:0] SEL_RADDR = 2'd2;
    localparam logic [1:0] SEL_MASK  = 2'd3;

    // Byte phase inside an R,G,B triplet
    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } byte_phase_t;

endpackage

// File: rtl/clut_palette_ram.sv
module clut_palette_ram
    import clut_pkg::*;
#(
    parameter int IDX_W = CLUT_IDX_W,
    parameter int CH_W  = CLUT_CH_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IDX_W-1:0]    waddr,
    input  logic [3*CH_W-1:0]   wdata,
    input  logic [IDX_W-1:0]    pix_addr,
    input  logic [IDX_W-1:0]    host_addr,
    output logic [3*CH_W-1:0]   pix_q,
    output logic [3*CH_W-1:0]   host_word
);
    localparam int DEPTH  = 1 << IDX_W;
    localparam int WORD_W = 3 * CH_W;

    logic [WORD_W-1:0] store [DEPTH];

    // Write port: palette contents carry no reset
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Pixel read port, registered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q <= '0;
        end else begin
            pix_q <= store[pix_addr];
        end
    end

    // Host read port, combinational, captured by the host block
    assign host_word = store[host_addr];

endmodule

// File: rtl/clut_host_port.sv
module clut_host_port
    import clut_pkg::*;
#(
    parameter int IDX_W = CLUT_IDX_W,
    parameter int CH_W  = CLUT_CH_W,
    parameter int LO_W  = CLUT_LO_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [1:0]          host_sel,
    input  logic [CH_W-1:0]     host_wdata,
    input  logic                dac6,
    input  logic [3*CH_W-1:0]   rd_word,
    output logic                mem_we,
    output logic [IDX_W-1:0]    mem_waddr,
    output logic [3*CH_W-1:0]   mem_wdata,
    output logic [IDX_W-1:0]    rd_addr,
    output logic [IDX_W-1:0]    mask_q,
    output logic [CH_W-1:0]     host_rdata
);
    localparam int HI_W = CH_W - LO_W;

    byte_phase_t wr_ph, wr_ph_nx;
    byte_phase_t rd_ph, rd_ph_nx;

    logic [IDX_W-1:0] waddr_q, raddr_q;
    logic [CH_W-1:0]  red_q, grn_q;
    logic [CH_W-1:0]  rdata_q, rdata_nx;
    logic [CH_W-1:0]  wbyte, rbyte_raw, rbyte;

    logic waddr_ld, raddr_ld, mask_ld, data_wr, data_rd, rd_any;

    assign waddr_ld = host_wr && (host_sel == SEL_WADDR);
    assign raddr_ld = host_wr && (host_sel == SEL_RADDR);
    assign mask_ld  = host_wr && (host_sel == SEL_MASK);
    assign data_wr  = host_wr && (host_sel == SEL_DATA);
    assign rd_any   = host_rd && !host_wr;
    assign data_rd  = rd_any && (host_sel == SEL_DATA);

    // Incoming byte, narrowed in 6-bit mode
    assign wbyte = dac6 ? {host_wdata[HI_W-1:0], {LO_W{1'b0}}} : host_wdata;

    // Write-sequence next state
    always_comb begin
        wr_ph_nx = wr_ph;
        if (waddr_ld) begin
            wr_ph_nx = PH_RED;
        end else if (data_wr) begin
            unique case (wr_ph)
                PH_RED:   wr_ph_nx = PH_GREEN;
                PH_GREEN: wr_ph_nx = PH_BLUE;
                PH_BLUE:  wr_ph_nx = PH_RED;
                default:  wr_ph_nx = PH_RED;
            endcase
        end
    end

    // Read-sequence next state
    always_comb begin
        rd_ph_nx = rd_ph;
        if (raddr_ld) begin
            rd_ph_nx = PH_RED;
        end else if (data_rd) begin
            unique case (rd_ph)
                PH_RED:   rd_ph_nx = PH_GREEN;
                PH_GREEN: rd_ph_nx = PH_BLUE;
                PH_BLUE:  rd_ph_nx = PH_RED;
                default:  rd_ph_nx = PH_RED;
            endcase
        end
    end

    // State registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ph <= PH_RED;
            rd_ph <= PH_RED;
        end else begin
            wr_ph <= wr_ph_nx;
            rd_ph <= rd_ph_nx;
        end
    end

    // Addresses and staged bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            waddr_q <= '0;
            raddr_q <= '0;
            red_q   <= '0;
            grn_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (waddr_ld) begin
                waddr_q <= host_wdata[IDX_W-1:0];
            end else if (data_wr && wr_ph == PH_BLUE) begin
                waddr_q <= waddr_q + 1'b1;
            end
            if (raddr_ld) begin
                raddr_q <= host_wdata[IDX_W-1:0];
            end else if (data_rd && rd_ph == PH_BLUE) begin
                raddr_q <= raddr_q + 1'b1;
            end
            if (data_wr && wr_ph == PH_RED) begin
                red_q <= wbyte;
            end
            if (data_wr && wr_ph == PH_GREEN) begin
                grn_q <= wbyte;
            end
            if (rd_any) begin
                rdata_q <= rdata_nx;
            end
        end
    end

    // Mask: left unreset on purpose, software loads it
    always_ff @(posedge clk) begin
        if (mask_ld) begin
            mask_q <= host_wdata[IDX_W-1:0];
        end
    end

    // Outputs
    always_comb begin
        unique case (rd_ph)
            PH_RED:   rbyte_raw = rd_word[3*CH_W-1:2*CH_W];
            PH_GREEN: rbyte_raw = rd_word[2*CH_W-1:CH_W];
            PH_BLUE:  rbyte_raw = rd_word[CH_W-1:0];
            default:  rbyte_raw = '0;
        endcase
        rbyte = dac6 ? {{LO_W{1'b0}}, rbyte_raw[CH_W-1:LO_W]} : rbyte_raw;
        unique case (host_sel)
            SEL_WADDR: rdata_nx = CH_W'(waddr_q);
            SEL_DATA:  rdata_nx = rbyte;
            SEL_RADDR: rdata_nx = CH_W'(raddr_q);
            SEL_MASK:  rdata_nx = CH_W'(mask_q);
            default:   rdata_nx = '0;
        endcase
        mem_we     = data_wr && (wr_ph == PH_BLUE);
        mem_waddr  = waddr_q;
        mem_wdata  = {red_q, grn_q, wbyte};
        rd_addr    = raddr_q;
        host_rdata = rdata_q;
    end

    // R3
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_ld |=> (mask_q == $past(host_wdata[IDX_W-1:0])));

    // R4
    waddr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && wr_ph == PH_BLUE) |=> (waddr_q == $past(waddr_q) + 1'b1));

    // R4
    red_to_green_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && wr_ph == PH_RED) |=> (wr_ph == PH_GREEN && !$past(mem_we)));

    // R5
    waddr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        waddr_ld |=> (wr_ph == PH_RED && waddr_q == $past(host_wdata[IDX_W-1:0])));

    // R6
    raddr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raddr_ld |=> (rd_ph == PH_RED && raddr_q == $past(host_wdata[IDX_W-1:0])));

    // R8
    six_bit_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && dac6) |=> (host_rdata[CH_W-1:CH_W-LO_W] == '0));

endmodule

// File: rtl/clut_pixel_pipe.sv
module clut_pixel_pipe
    import clut_pkg::*;
#(
    parameter int IDX_W = CLUT_IDX_W,
    parameter int CH_W  = CLUT_CH_W,
    parameter int LO_W  = CLUT_LO_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3*CH_W-1:0]   pix_data,
    input  logic                pix_bypass,
    input  logic                dac6,
    input  logic [IDX_W-1:0]    mask_q,
    input  logic [3*CH_W-1:0]   look_word,
    output logic [IDX_W-1:0]    look_addr,
    output logic [3*CH_W-1:0]   rgb_out
);
    localparam int WORD_W = 3 * CH_W;

    logic [WORD_W-1:0] s1_raw, s2_raw, pick;
    logic              s1_byp, s2_byp, s1_m6, s2_m6;

    // Stage 1: masked index and pixel attributes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            look_addr <= '0;
            s1_raw    <= '0;
            s1_byp    <= 1'b0;
            s1_m6     <= 1'b0;
        end else begin
            look_addr <= pix_data[IDX_W-1:0] & mask_q;
            s1_raw    <= pix_data;
            s1_byp    <= pix_bypass;
            s1_m6     <= dac6;
        end
    end

    // Stage 2: aligned with the registered palette read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_raw <= '0;
            s2_byp <= 1'b0;
            s2_m6  <= 1'b0;
        end else begin
            s2_raw <= s1_raw;
            s2_byp <= s1_byp;
            s2_m6  <= s1_m6;
        end
    end

    assign pick = s2_byp ? s2_raw : look_word;

    // Per-channel low-bit clearing in 6-bit mode
    for (genvar ch = 0; ch < 3; ch++) begin : g_chan
        assign rgb_out[ch*CH_W +: LO_W] =
            s2_m6 ? {LO_W{1'b0}} : pick[ch*CH_W +: LO_W];
        assign rgb_out[ch*CH_W+LO_W +: CH_W-LO_W] =
            pick[ch*CH_W+LO_W +: CH_W-LO_W];
    end

    // R2
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_bypass && !dac6) |-> ##2 (rgb_out == $past(pix_data, 2)));

    // R9
    low_bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac6 |-> ##2 (rgb_out[0 +: LO_W] == '0 &&
                      rgb_out[CH_W +: LO_W] == '0 &&
                      rgb_out[2*CH_W +: LO_W] == '0));

endmodule

// File: rtl/clut_mask_stage.sv
module clut_mask_stage
    import clut_pkg::*;
#(
    parameter int IDX_W = CLUT_IDX_W,
    parameter int CH_W  = CLUT_CH_W,
    parameter int LO_W  = CLUT_LO_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3*CH_W-1:0]   pix_data,
    input  logic                pix_bypass,
    input  logic                dac6_mode,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [1:0]          host_sel,
    input  logic [CH_W-1:0]     host_wdata,
    output logic [CH_W-1:0]     host_rdata,
    output logic [CH_W-1:0]     red_out,
    output logic [CH_W-1:0]     grn_out,
    output logic [CH_W-1:0]     blu_out
);
    localparam int WORD_W = 3 * CH_W;

    logic              mem_we;
    logic [IDX_W-1:0]  mem_waddr, rd_addr, mask_q, look_addr;
    logic [WORD_W-1:0] mem_wdata, host_word, look_word, rgb;

    clut_host_port #(.IDX_W(IDX_W), .CH_W(CH_W), .LO_W(LO_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .dac6       (dac6_mode),
        .rd_word    (host_word),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .rd_addr    (rd_addr),
        .mask_q     (mask_q),
        .host_rdata (host_rdata)
    );

    clut_palette_ram #(.IDX_W(IDX_W), .CH_W(CH_W)) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (mem_we),
        .waddr     (mem_waddr),
        .wdata     (mem_wdata),
        .pix_addr  (look_addr),
        .host_addr (rd_addr),
        .pix_q     (look_word),
        .host_word (host_word)
    );

    clut_pixel_pipe #(.IDX_W(IDX_W), .CH_W(CH_W), .LO_W(LO_W)) u_pix (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_data   (pix_data),
        .pix_bypass (pix_bypass),
        .dac6       (dac6_mode),
        .mask_q     (mask_q),
        .look_word  (look_word),
        .look_addr  (look_addr),
        .rgb_out    (rgb)
    );

    assign red_out = rgb[3*CH_W-1:2*CH_W];
    assign grn_out = rgb[2*CH_W-1:CH_W];
    assign blu_out = rgb[CH_W-1:0];

endmodule

// File: tb/clut_mask_stage_tb.sv
`timescale 1ns/1ps
module clut_mask_stage_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pix_data = '0;
    logic        pix_bypass = 1'b0;
    logic        dac6_mode = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [1:0]  host_sel = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata, red_out, grn_out, blu_out;

    int n_chk = 0;
    int n_bad = 0;

    logic [23:0] shadow [256];
    logic [7:0]  cur_mask;
    logic [7:0]  t_raddr;
    int          t_rph;

    always #2.5 clk = ~clk;

    clut_mask_stage u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_data   (pix_data),
        .pix_bypass (pix_bypass),
        .dac6_mode  (dac6_mode),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .red_out    (red_out),
        .grn_out    (grn_out),
        .blu_out    (blu_out)
    );

    function automatic logic [23:0] pal_fn(input int i);
        logic [7:0] r, g, b;
        r = 8'(i * 7 + 3);
        g = 8'(i) ^ 8'h5A;
        b = 8'(255 - i);
        return {r, g, b};
    endfunction

    function automatic logic [23:0] exp_px(input logic [23:0] d, input logic [7:0] m,
                                           input logic byp, input logic m6);
        logic [23:0] v;
        v = byp ? d : shadow[d[7:0] & m];
        if (m6) v = v & 24'hFCFCFC;
        return v;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [23:0] w, input int ph, input logic m6);
        logic [7:0] b;
        b = (ph == 0) ? w[23:16] : (ph == 1) ? w[15:8] : w[7:0];
        return m6 ? {2'b00, b[7:2]} : b;
    endfunction

    function automatic logic [7:0] store_byte(input logic [7:0] d, input logic m6);
        return m6 ? {d[5:0], 2'b00} : d;
    endfunction

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [1:0] sel, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_sel = sel;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    function automatic logic [23:0] rgb_now();
        return {red_out, grn_out, blu_out};
    endfunction

    // Random pixels with concurrent host data reads (R1, R2, R9, R10, R6, R8)
    task automatic run_stream(input int n);
        logic [23:0] ex_a, ex_b;
        logic [7:0]  ex_rd;
        bit va, vb, vr;
        va = 0; vb = 0; vr = 0; ex_a = '0; ex_b = '0; ex_rd = '0;
        for (int k = 0; k < n + 2; k++) begin
            @(negedge clk);
            if (vb) chk("R1/R2/R9/R10 pixel output", rgb_now(), ex_b);
            if (vr) chk("R6/R8/R10 host data read", {16'h0, host_rdata}, {16'h0, ex_rd});
            ex_b = ex_a; vb = va;
            host_rd = 1'b0; vr = 0;
            if (k < n) begin
                pix_data   = $urandom;
                pix_bypass = ($urandom % 4) == 0;
                dac6_mode  = $urandom % 2;
                ex_a = exp_px(pix_data, cur_mask, pix_bypass, dac6_mode);
                va = 1;
                if ($urandom % 2) begin
                    host_rd = 1'b1; host_sel = 2'd1;
                    ex_rd = exp_rd(shadow[t_raddr], t_rph, dac6_mode);
                    vr = 1;
                    if (t_rph == 2) begin t_rph = 0; t_raddr = t_raddr + 1; end
                    else t_rph++;
                end
            end else begin
                va = 0;
            end
        end
        pix_data = '0; pix_bypass = 1'b0; dac6_mode = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rb;
        logic [23:0] w;
        int seed_dummy;
        seed_dummy = $urandom(32'hC1A7_5EED);

        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 outputs in reset", rgb_now(), 24'h0);
        chk("R11 host_rdata in reset", {16'h0, host_rdata}, 24'h0);
        rst_n = 1'b1;
        hrd(2'd0, rb); chk("R11 write address after reset", {16'h0, rb}, 24'h0);
        hrd(2'd2, rb); chk("R11 read address after reset", {16'h0, rb}, 24'h0);

        // R3 mask load and readback
        hwr(2'd3, 8'hFF); cur_mask = 8'hFF;
        hrd(2'd3, rb); chk("R3 mask readback", {16'h0, rb}, 24'h0000FF);

        // Fill palette in 8-bit mode (R4)
        hwr(2'd0, 8'h00);
        for (int i = 0; i < 256; i++) begin
            w = pal_fn(i);
            hwr(2'd1, w[23:16]); hwr(2'd1, w[15:8]); hwr(2'd1, w[7:0]);
            shadow[i] = w;
        end
        hrd(2'd0, rb); chk("R4 write address wraps after 256 triplets", {16'h0, rb}, 24'h0);

        // R6 read sequence and increment
        hwr(2'd2, 8'd5);
        hrd(2'd1, rb); chk("R6 read red", {16'h0, rb}, {16'h0, shadow[5][23:16]});
        hrd(2'd1, rb); chk("R6 read green", {16'h0, rb}, {16'h0, shadow[5][15:8]});
        hrd(2'd1, rb); chk("R6 read blue", {16'h0, rb}, {16'h0, shadow[5][7:0]});
        hrd(2'd2, rb); chk("R6 read address incremented", {16'h0, rb}, 24'h6);
        hrd(2'd0, rb); chk("R6 write address independent", {16'h0, rb}, 24'h0);

        // R4 partial triplet leaves entry unchanged
        hwr(2'd0, 8'd10);
        hwr(2'd1, 8'h11); hwr(2'd1, 8'h22);
        hwr(2'd2, 8'd10);
        hrd(2'd1, rb); chk("R4 no commit before blue (red)", {16'h0, rb}, {16'h0, shadow[10][23:16]});
        hrd(2'd1, rb); chk("R4 no commit before blue (green)", {16'h0, rb}, {16'h0, shadow[10][15:8]});
        // R5 reload restarts at red
        hwr(2'd0, 8'd10);
        hwr(2'd1, 8'hA1); hwr(2'd1, 8'hB2); hwr(2'd1, 8'hC3);
        shadow[10] = 24'hA1B2C3;
        hrd(2'd0, rb); chk("R5 address advanced after triplet", {16'h0, rb}, 24'd11);
        hwr(2'd2, 8'd10);
        hrd(2'd1, rb); chk("R5 restart red", {16'h0, rb}, 24'hA1);
        hrd(2'd1, rb); chk("R5 restart green", {16'h0, rb}, 24'hB2);
        hrd(2'd1, rb); chk("R5 restart blue", {16'h0, rb}, 24'hC3);

        // R7/R8 six-bit writes and reads
        dac6_mode = 1'b1;
        hwr(2'd0, 8'd20);
        hwr(2'd1, 8'hFF); hwr(2'd1, 8'hC1); hwr(2'd1, 8'h3F);
        shadow[20] = {store_byte(8'hFF, 1), store_byte(8'hC1, 1), store_byte(8'h3F, 1)};
        hwr(2'd2, 8'd20);
        hrd(2'd1, rb); chk("R8 6-bit read red", {16'h0, rb}, 24'h3F);
        hrd(2'd1, rb); chk("R8 6-bit read green", {16'h0, rb}, 24'h01);
        hrd(2'd1, rb); chk("R8 6-bit read blue", {16'h0, rb}, 24'h3F);
        dac6_mode = 1'b0;
        hwr(2'd2, 8'd20);
        hrd(2'd1, rb); chk("R7 stored red", {16'h0, rb}, 24'hFC);
        hrd(2'd1, rb); chk("R7 stored green", {16'h0, rb}, 24'h04);
        hrd(2'd1, rb); chk("R7 stored blue", {16'h0, rb}, 24'hFC);

        // R1 latency with mask 0x0F: 0xF3 selects entry 3
        hwr(2'd3, 8'h0F); cur_mask = 8'h0F;
        repeat (3) @(negedge clk);
        chk("R1 idle output is entry 0", rgb_now(), shadow[0]);
        pix_data = 24'h0000F3;
        @(negedge clk);
        pix_data = 24'h0;
        chk("R1 output not yet changed after one cycle", rgb_now(), shadow[0]);
        @(negedge clk);
        chk("R1 masked lookup after two cycles", rgb_now(), shadow[3]);

        // R2 bypass ignores mask: data with index bits outside mask
        pix_data = 24'h123456; pix_bypass = 1'b1;
        @(negedge clk);
        pix_data = 24'h0; pix_bypass = 1'b0;
        @(negedge clk);
        chk("R2 bypass passes word", rgb_now(), 24'h123456);

        // Random streams under several masks
        foreach (shadow[i]) begin end
        begin
            logic [7:0] masks [4];
            masks[0] = 8'hFF; masks[1] = 8'hA5; masks[2] = 8'h0F; masks[3] = 8'h00;
            for (int m = 0; m < 4; m++) begin
                hwr(2'd3, masks[m]); cur_mask = masks[m];
                t_raddr = 8'($urandom);
                hwr(2'd2, t_raddr); t_rph = 0;
                run_stream(1500);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule